// File: doc/BRIEF.md
# Multicycle Datapath Sequencer

This block is the hardwired sequencer of a multicycle processor. Each instruction takes three to five clock cycles. The block keeps the current step in a 4-bit state register. From that state it drives the write enables, the operand selects and the ALU operation code of a shared datapath. The datapath has one memory, one ALU, an instruction register, a data register, operand registers A and B, and an ALU result register.

Five instruction kinds are supported:

- word load
- word store
- register-register arithmetic, with the operation taken from the function field
- OR with a zero-extended immediate
- branch on equal

The opcode is sampled only in the decode step. The ALU zero flag is used only while a branch executes. The block also produces a merged PC load strobe, so the datapath needs no gating of its own.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the state to 0000 on the next rising edge, from any state. This holds in the middle of an instruction too.
- R2: State 0000 (fetch) asserts `mem_read`, `ir_write` and `pc_write`. It also sets `iord`=0, `alu_sel_a`=0, `alu_sel_b`=001 (constant 4), `alu_op`=00 (add) and `pc_src`=0. The next state is always 0001.
- R3: State 0001 (decode) sets `alu_sel_a`=0, `alu_sel_b`=011 (sign-extended immediate shifted left 2) and `alu_op`=00, with no write enable set. It branches on the opcode as follows:
  - 0x23 to 0010
  - 0x2B to 0101
  - 0x00 to 0111
  - 0x0D to 1001
  - 0x04 to 1011
- R4: Load: state 0010 sets `alu_sel_a`=1, `alu_sel_b`=010 (sign-extended) and add. State 0011 sets `mem_read`=1 and `iord`=1. State 0100 sets `reg_write`=1, `mem_to_reg`=1 and `reg_dst`=0. The state then returns to 0000.
- R5: Store: state 0101 computes the address in the same way as the load. State 0110 sets `mem_write`=1 and `iord`=1. The state then returns to 0000.
- R6: Register-register: state 0111 sets `alu_sel_a`=1, `alu_sel_b`=000 (rt) and `alu_op`=10 (function field). State 1000 sets `reg_write`=1, `reg_dst`=1 and `mem_to_reg`=0. The state then returns to 0000.
- R7: OR-immediate: state 1001 sets `alu_sel_a`=1, `alu_sel_b`=100 (zero-extended) and `alu_op`=11 (OR). State 1010 sets `reg_write`=1, `reg_dst`=0 and `mem_to_reg`=0. The state then returns to 0000.
- R8: Branch: state 1011 sets `alu_sel_a`=1, `alu_sel_b`=000, `alu_op`=01 (subtract), `pc_write_cond`=1 and `pc_src`=1. The state then returns to 0000.
- R9: Any other opcode seen in decode returns the state to 0000. No write enable is asserted on that path.
- R10: Outside the states named in R2 to R8, every write enable and read strobe is 0. The opcode has no effect in any state other than decode.
- R11: `pc_load` is 1 exactly in fetch, or in branch execute while `alu_zero` is 1. In every other state the zero flag has no effect on `pc_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write if the ALU zero flag is set |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| alu_sel_a | output | 1 | First operand: 0 PC, 1 register A |
| alu_sel_b | output | 3 | Second operand select code |
| alu_op | output | 2 | ALU operation code |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_write | output | 1 | Instruction register load |
| reg_write | output | 1 | Register file write |
| mem_to_reg | output | 1 | Write data: 0 ALU output, 1 memory data register |
| reg_dst | output | 1 | Destination: 0 rt field, 1 rd field |
| pc_load | output | 1 | Merged PC load strobe |
| state | output | 4 | Current state code |

## Verification
The hardest cases depend on timing. One is a reset that arrives in the middle of a load or store. The other is an opcode or zero flag that changes while the sequencer is in a state that must ignore it. Directed sequences first walk each instruction kind and each unknown opcode through its full path. A long random phase then follows. In that phase the opcode and the zero flag change every cycle, and reset is pulsed at random points. A behavioural model tracks the expected state and compares all outputs every cycle. This puts stray opcodes, zero pulses and resets into every state.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int ST_W   = 4;
    localparam int OP_W   = 6;
    localparam int AOP_W  = 2;
    localparam int SRCB_W = 3;

    typedef enum logic [ST_W-1:0] {
        S_FETCH    = 4'b0000,
        S_DECODE   = 4'b0001,
        S_LD_ADDR  = 4'b0010,
        S_LD_READ  = 4'b0011,
        S_LD_WB    = 4'b0100,
        S_ST_ADDR  = 4'b0101,
        S_ST_WRITE = 4'b0110,
        S_RR_EXEC  = 4'b0111,
        S_RR_WB    = 4'b1000,
        S_OI_EXEC  = 4'b1001,
        S_OI_WB    = 4'b1010,
        S_BR_EXEC  = 4'b1011
    } state_e;

    localparam logic [OP_W-1:0] OPC_RR  = 6'h00;
    localparam logic [OP_W-1:0] OPC_BEQ = 6'h04;
    localparam logic [OP_W-1:0] OPC_ORI = 6'h0D;
    localparam logic [OP_W-1:0] OPC_LW  = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW  = 6'h2B;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD  = 2'b00,
        AOP_SUB  = 2'b01,
        AOP_FUNC = 2'b10,
        AOP_OR   = 2'b11
    } aluop_e;

    typedef enum logic [SRCB_W-1:0] {
        SB_RT       = 3'b000,
        SB_FOUR     = 3'b001,
        SB_SEXT     = 3'b010,
        SB_SEXT_SH2 = 3'b011,
        SB_ZEXT     = 3'b100
    } srcb_e;

    typedef struct packed {
        logic   pc_write;
        logic   pc_write_cond;
        logic   pc_src;
        logic   alu_sel_a;
        srcb_e  alu_sel_b;
        aluop_e alu_op;
        logic   mem_read;
        logic   mem_write;
        logic   iord;
        logic   ir_write;
        logic   reg_write;
        logic   mem_to_reg;
        logic   reg_dst;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c.pc_write      = 1'b0;
        c.pc_write_cond = 1'b0;
        c.pc_src        = 1'b0;
        c.alu_sel_a     = 1'b0;
        c.alu_sel_b     = SB_RT;
        c.alu_op        = AOP_ADD;
        c.mem_read      = 1'b0;
        c.mem_write     = 1'b0;
        c.iord          = 1'b0;
        c.ir_write      = 1'b0;
        c.reg_write     = 1'b0;
        c.mem_to_reg    = 1'b0;
        c.reg_dst       = 1'b0;
        return c;
    endfunction

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return (op == OPC_RR) || (op == OPC_BEQ) || (op == OPC_ORI) ||
               (op == OPC_LW) || (op == OPC_SW);
    endfunction

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
    import mcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e next_i,
    output state_e state_o
);

    always_ff @(posedge clk) begin
        if (rst) state_o <= S_FETCH;
        else     state_o <= next_i;
    end

    a_r1_reset_to_fetch: assert property (@(posedge clk) rst |=> state_o == S_FETCH);

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e          state_i,
    input  logic [OP_W-1:0] opcode_i,
    output state_e          next_o
);

    state_e dispatch;

    always_comb begin
        case (opcode_i)
            OPC_LW:  dispatch = S_LD_ADDR;
            OPC_SW:  dispatch = S_ST_ADDR;
            OPC_RR:  dispatch = S_RR_EXEC;
            OPC_ORI: dispatch = S_OI_EXEC;
            OPC_BEQ: dispatch = S_BR_EXEC;
            default: dispatch = S_FETCH;
        endcase
    end

    always_comb begin
        case (state_i)
            S_FETCH:   next_o = S_DECODE;
            S_DECODE:  next_o = dispatch;
            S_LD_ADDR: next_o = S_LD_READ;
            S_LD_READ: next_o = S_LD_WB;
            S_ST_ADDR: next_o = S_ST_WRITE;
            S_RR_EXEC: next_o = S_RR_WB;
            S_OI_EXEC: next_o = S_OI_WB;
            default:   next_o = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_e state_i,
    output ctrl_t  ctrl_o
);

    always_comb begin
        ctrl_o = ctrl_idle();
        case (state_i)
            S_FETCH: begin
                ctrl_o.mem_read  = 1'b1;
                ctrl_o.ir_write  = 1'b1;
                ctrl_o.pc_write  = 1'b1;
                ctrl_o.alu_sel_b = SB_FOUR;
            end
            S_DECODE: begin
                ctrl_o.alu_sel_b = SB_SEXT_SH2;
            end
            S_LD_ADDR, S_ST_ADDR: begin
                ctrl_o.alu_sel_a = 1'b1;
                ctrl_o.alu_sel_b = SB_SEXT;
            end
            S_LD_READ: begin
                ctrl_o.mem_read = 1'b1;
                ctrl_o.iord     = 1'b1;
            end
            S_LD_WB: begin
                ctrl_o.reg_write  = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
            end
            S_ST_WRITE: begin
                ctrl_o.mem_write = 1'b1;
                ctrl_o.iord      = 1'b1;
            end
            S_RR_EXEC: begin
                ctrl_o.alu_sel_a = 1'b1;
                ctrl_o.alu_op    = AOP_FUNC;
            end
            S_RR_WB: begin
                ctrl_o.reg_write = 1'b1;
                ctrl_o.reg_dst   = 1'b1;
            end
            S_OI_EXEC: begin
                ctrl_o.alu_sel_a = 1'b1;
                ctrl_o.alu_sel_b = SB_ZEXT;
                ctrl_o.alu_op    = AOP_OR;
            end
            S_OI_WB: begin
                ctrl_o.reg_write = 1'b1;
            end
            S_BR_EXEC: begin
                ctrl_o.alu_sel_a     = 1'b1;
                ctrl_o.alu_op        = AOP_SUB;
                ctrl_o.pc_write_cond = 1'b1;
                ctrl_o.pc_src        = 1'b1;
            end
            default: ctrl_o = ctrl_idle();
        endcase
    end

endmodule

// File: rtl/mcc_pc_gate.sv
module mcc_pc_gate (
    input  logic pc_write_i,
    input  logic pc_write_cond_i,
    input  logic zero_i,
    output logic pc_load_o
);

    always_comb pc_load_o = pc_write_i | (pc_write_cond_i & zero_i);

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    input  logic              alu_zero,
    output logic              pc_write,
    output logic              pc_write_cond,
    output logic              pc_src,
    output logic              alu_sel_a,
    output logic [SRCB_W-1:0] alu_sel_b,
    output logic [AOP_W-1:0]  alu_op,
    output logic              mem_read,
    output logic              mem_write,
    output logic              iord,
    output logic              ir_write,
    output logic              reg_write,
    output logic              mem_to_reg,
    output logic              reg_dst,
    output logic              pc_load,
    output logic [ST_W-1:0]   state
);

    state_e cur;
    state_e nxt;
    ctrl_t  ctl;

    mcc_state_reg u_sreg (
        .clk     (clk),
        .rst     (rst),
        .next_i  (nxt),
        .state_o (cur)
    );

    mcc_next_state u_next (
        .state_i  (cur),
        .opcode_i (opcode),
        .next_o   (nxt)
    );

    mcc_ctrl_decode u_dec (
        .state_i (cur),
        .ctrl_o  (ctl)
    );

    mcc_pc_gate u_pcg (
        .pc_write_i      (ctl.pc_write),
        .pc_write_cond_i (ctl.pc_write_cond),
        .zero_i          (alu_zero),
        .pc_load_o       (pc_load)
    );

    assign pc_write      = ctl.pc_write;
    assign pc_write_cond = ctl.pc_write_cond;
    assign pc_src        = ctl.pc_src;
    assign alu_sel_a     = ctl.alu_sel_a;
    assign alu_sel_b     = ctl.alu_sel_b;
    assign alu_op        = ctl.alu_op;
    assign mem_read      = ctl.mem_read;
    assign mem_write     = ctl.mem_write;
    assign iord          = ctl.iord;
    assign ir_write      = ctl.ir_write;
    assign reg_write     = ctl.reg_write;
    assign mem_to_reg    = ctl.mem_to_reg;
    assign reg_dst       = ctl.reg_dst;
    assign state         = cur;

    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        cur == S_FETCH |=> cur == S_DECODE);

    a_r4_load_read_after_addr: assert property (@(posedge clk) disable iff (rst)
        cur == S_LD_ADDR |=> (cur == S_LD_READ && mem_read && iord));

    a_r5_store_write_follows_addr: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> $past(cur) == S_ST_ADDR);

    a_r8_branch_returns: assert property (@(posedge clk) disable iff (rst)
        cur == S_BR_EXEC |=> cur == S_FETCH);

    a_r9_unknown_op_fetch: assert property (@(posedge clk) disable iff (rst)
        (cur == S_DECODE && !op_known(opcode)) |=> cur == S_FETCH);

    a_r10_regwrite_after_exec: assert property (@(posedge clk) disable iff (rst)
        reg_write |-> ($past(cur) == S_LD_READ || $past(cur) == S_RR_EXEC ||
                       $past(cur) == S_OI_EXEC));

    a_r11_pc_load_source: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (cur == S_FETCH || (cur == S_BR_EXEC && alu_zero)));

endmodule

// File: tb/mcc_ctrl_test.sv
module mcc_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       pc_write, pc_write_cond, pc_src, alu_sel_a;
    logic [2:0] alu_sel_b;
    logic [1:0] alu_op;
    logic       mem_read, mem_write, iord, ir_write, reg_write, mem_to_reg, reg_dst, pc_load;
    logic [3:0] state;

    int n_cmp = 0;
    int n_bad = 0;
    int m_state = 0;

    mcc_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_src(pc_src),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .alu_op(alu_op),
        .mem_read(mem_read), .mem_write(mem_write), .iord(iord), .ir_write(ir_write),
        .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
        .pc_load(pc_load), .state(state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected packed outputs:
    // {state4, pcw, pcwc, pcsrc, sela, selb3, op2, mrd, mwr, iord, irw, rw, m2r, rdst, pcld}
    function automatic logic [20:0] expect_out(int s, logic z);
        logic [20:0] e;
        e = '0;
        e[20:17] = s[3:0];
        case (s)
            0:  begin e[16] = 1; e[12:10] = 3'd1; e[7] = 1; e[4] = 1; e[0] = 1; end
            1:  begin e[12:10] = 3'd3; end
            2, 5: begin e[13] = 1; e[12:10] = 3'd2; end
            3:  begin e[7] = 1; e[5] = 1; end
            4:  begin e[3] = 1; e[2] = 1; end
            6:  begin e[6] = 1; e[5] = 1; end
            7:  begin e[13] = 1; e[9:8] = 2'd2; end
            8:  begin e[3] = 1; e[1] = 1; end
            9:  begin e[13] = 1; e[12:10] = 3'd4; e[9:8] = 2'd3; end
            10: begin e[3] = 1; end
            11: begin e[15] = 1; e[14] = 1; e[13] = 1; e[9:8] = 2'd1; e[0] = z; end
            default: ;
        endcase
        return e;
    endfunction

    function automatic int model_next(int s, logic [5:0] op, logic r);
        if (r) return 0;
        if (s == 0) return 1;
        if (s == 1) begin
            if (op == 6'h23) return 2;
            if (op == 6'h2B) return 5;
            if (op == 6'h00) return 7;
            if (op == 6'h0D) return 9;
            if (op == 6'h04) return 11;
            return 0;
        end
        if (s == 2 || s == 3 || s == 5 || s == 7 || s == 9) return s + 1;
        return 0;
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R4";
            5, 6: return "R5";
            7, 8: return "R6";
            9, 10: return "R7";
            11: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic step(input logic [5:0] op, input logic z, input logic r, input string tag);
        logic [20:0] got, exp;
        opcode = op; alu_zero = z; rst = r;
        #1;
        got = {state, pc_write, pc_write_cond, pc_src, alu_sel_a, alu_sel_b, alu_op,
               mem_read, mem_write, iord, ir_write, reg_write, mem_to_reg, reg_dst, pc_load};
        exp = expect_out(m_state, z);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s state=%0d actual=%h expected=%h",
                     (tag == "") ? req_of(m_state) : tag, m_state, got, exp);
        end
        m_state = model_next(m_state, op, r);
        @(negedge clk);
    endtask

    // run one instruction from fetch: fetch, decode, then hold until back at fetch
    task automatic run_instr(input logic [5:0] op, input logic z, input string tag);
        step(op, z, 1'b0, "R2");
        step(op, z, 1'b0, "R3");
        while (m_state != 0) step(6'h3F, z, 1'b0, tag); // R10: opcode ignored after decode
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(6'h23, 1'b1, 1'b1, "R1");
        step(6'h23, 1'b1, 1'b1, "R1");
        step(6'h00, 1'b0, 1'b0, "R1");   // R1: first cycle after reset is fetch
        while (m_state != 0) step(6'h00, 1'b0, 1'b0, "");
        run_instr(6'h23, 1'b0, "R4");
        run_instr(6'h2B, 1'b1, "R5");
        run_instr(6'h00, 1'b1, "R6");
        run_instr(6'h0D, 1'b1, "R7");
        run_instr(6'h04, 1'b1, "R8");    // R11: zero set, pc_load in branch
        run_instr(6'h04, 1'b0, "R8");    // R11: zero clear, no pc_load
        run_instr(6'h3F, 1'b1, "R9");
        run_instr(6'h02, 1'b0, "R9");
        // R1: reset in the middle of a load
        step(6'h23, 1'b0, 1'b0, "R2");
        step(6'h23, 1'b0, 1'b0, "R3");
        step(6'h23, 1'b0, 1'b0, "R4");
        step(6'h23, 1'b0, 1'b1, "R4");
        step(6'h23, 1'b0, 1'b0, "R1");
        // random phase: opcode, zero and occasional reset change every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] op;
            int k;
            k = $urandom_range(0, 6);
            case (k)
                0: op = 6'h23; 1: op = 6'h2B; 2: op = 6'h00; 3: op = 6'h0D;
                4: op = 6'h04; default: op = 6'($urandom_range(0, 63));
            endcase
            step(op, 1'($urandom_range(0, 1)), ($urandom_range(0, 60) == 0), "");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule